// File: doc/BRIEF.md
# Two-Channel Byte DMA Packing Engine

This block sits between two 8-bit peripheral DMA channels and a 32-bit memory path. A channel set to move data toward memory hands over one byte per acknowledge. The engine collects four of those bytes into a word and offers the word on a valid/ready output port. A channel set to move data toward the peripheral is first filled with a word through a request/ready fetch port. The engine then hands that word out one byte per acknowledge.

Each channel keeps its own partial word and byte position, so the two channels can be served alternately without disturbing each other. A round-robin arbiter chooses which requesting, eligible channel is acknowledged in each cycle. A single endian input decides whether the first byte of a word sits in the low lane or the high lane. Bus ownership, address generation and peripheral strobe timing belong to neighbouring logic.

Top module: `bytepack_dma`

## Requirements
- R1: While reset is held, every acknowledge output is high (inactive) even with requests asserted, `wr_valid` is 0 and `rd_req` is 0.
- R2: In any cycle at most one `ch_ack_n` bit is low, and only for a channel whose `ch_req` bit is high. The byte moves on the rising clock edge that ends the acknowledge cycle.
- R3: With `big_endian`=0, four consecutive bytes of a channel whose `ch_to_mem` bit is 1 form one word. The first byte goes to bits 7:0, the second to 15:8, the third to 23:16 and the fourth to 31:24.
- R4: With `big_endian`=1, packing places the first byte in bits 31:24, the second in 23:16, the third in 15:8 and the fourth in 7:0.
- R5: For a channel whose `ch_to_mem` bit is 0, `per_rdata_out` shows a byte of the channel's loaded word during each acknowledge. With `big_endian`=0 the bytes come from bits 7:0 upward. With `big_endian`=1 they come from bits 31:24 downward.
- R6: When several eligible channels request, grants rotate. The search starts at the channel after the one last served, and channel 0 is first after reset. The rotation pointer moves only when a byte is transferred.
- R7: Each channel keeps its own byte position and partial word, so interleaved service never mixes bytes between channels.
- R8: A completed word appears with `wr_valid`=1. `wr_data` and `wr_chan` hold until `wr_ready` is sampled high. Meanwhile the owning channel is not acknowledged, and no other channel is acknowledged for the fourth byte of its word.
- R9: `rd_req` asks for a word for channel `rd_chan` only when that channel is an unpack channel with no word loaded. A channel loses its word only when its fourth byte is delivered. `rd_chan` holds until `rd_ready` is sampled high, and the word on `rd_data` is loaded at that edge with the byte position restarting at the first byte.
- R10: `wr_chan` gives the index of the channel whose four bytes formed `wr_data`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| big_endian | input | 1 | 1 selects high-lane-first byte order |
| ch_to_mem | input | NUM_CH | Per channel: 1 packs toward memory, 0 unpacks toward peripheral |
| ch_req | input | NUM_CH | Per-channel DMA request |
| ch_ack_n | output | NUM_CH | Per-channel acknowledge, active low |
| per_wdata_in | input | 8 | Byte from the peripheral for a packing channel |
| per_rdata_out | output | 8 | Byte to the peripheral for an unpacking channel |
| wr_valid | output | 1 | Packed word available |
| wr_ready | input | 1 | Word sink accepts the packed word |
| wr_data | output | 32 | Packed word |
| wr_chan | output | max(1,clog2(NUM_CH)) | Channel that produced the packed word |
| rd_req | output | 1 | Word fetch request |
| rd_ready | input | 1 | Fetch word supplied on rd_data |
| rd_data | input | 32 | Fetched word |
| rd_chan | output | max(1,clog2(NUM_CH)) | Channel the fetch is for |

## Verification
The bench builds the engine with the default NUM_CH of 2. With two channels, every run of contested cycles shows the alternation directly, and any single-channel stall exposes whether the pointer moved without a transfer. Mixed-direction phases pair one packing and one unpacking channel, so the shared byte path and both word ports are active in the same window. Low `wr_ready` and `rd_ready` rates keep a packed word parked, which brings the fourth-byte hold-off and the owner stall into reach.

// File: rtl/bytepack_pkg.sv
package bytepack_pkg;
  localparam int BYTE_W = 8;
  localparam int WORD_W = 32;
  localparam int LANES  = WORD_W / BYTE_W;
  localparam int LANE_W = $clog2(LANES);

  typedef logic [BYTE_W-1:0] byte_t;
  typedef logic [WORD_W-1:0] word_t;
  typedef logic [LANE_W-1:0] lane_t;

  // Lane that byte number k of a word occupies under the chosen order
  function automatic lane_t lane_of(input lane_t k, input logic big);
    return big ? (lane_t'(LANES - 1) - k) : k;
  endfunction

  function automatic word_t lane_insert(input word_t w, input lane_t lane, input byte_t b);
    word_t r;
    r = w;
    r[int'(lane)*BYTE_W +: BYTE_W] = b;
    return r;
  endfunction

  function automatic byte_t lane_extract(input word_t w, input lane_t lane);
    return w[int'(lane)*BYTE_W +: BYTE_W];
  endfunction
endpackage

// File: rtl/bp_rr_arbiter.sv
module bp_rr_arbiter #(
  parameter int N = 2,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  cand,
  output logic [N-1:0]  gnt,
  output logic [IW-1:0] gnt_idx,
  output logic          any
);
  logic [IW-1:0] ptr;

  always_comb begin
    gnt     = '0;
    gnt_idx = ptr;
    any     = 1'b0;
    for (int k = 1; k <= N; k++) begin
      int idx;
      idx = int'(ptr) + k;
      if (idx >= N) idx = idx - N;
      if (!any && cand[IW'(idx)]) begin
        any          = 1'b1;
        gnt_idx      = IW'(idx);
        gnt[IW'(idx)] = 1'b1;
      end
    end
  end

  // Pointer moves only on a transfer (R6)
  always_ff @(posedge clk) begin
    if (!rst_n)   ptr <= IW'(N - 1);
    else if (any) ptr <= gnt_idx;
  end

  a_r2_single_grant: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt));

  a_r6_no_repeat_when_contested: assert property (@(posedge clk) disable iff (!rst_n)
    (any && $past(any) && gnt_idx == $past(gnt_idx)) |-> (cand == gnt));
endmodule

// File: rtl/bp_channel.sv
module bp_channel
  import bytepack_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  big,
  input  logic  to_mem,
  input  logic  take,
  input  byte_t byte_in,
  input  logic  load,
  input  word_t load_word,
  input  logic  slot_busy,
  input  logic  slot_mine,
  output logic  elig,
  output byte_t byte_out,
  output logic  pack_done,
  output word_t packed_word,
  output logic  empty_rx
);
  word_t word_q;
  lane_t cnt_q;
  logic  full_q;
  lane_t lane;
  logic  last;

  assign lane        = lane_of(cnt_q, big);
  assign last        = (cnt_q == lane_t'(LANES - 1));
  assign packed_word = lane_insert(word_q, lane, byte_in);
  assign byte_out    = lane_extract(word_q, lane);
  assign pack_done   = take && to_mem && last;
  assign empty_rx    = !to_mem && !full_q;
  // Packing: stalled while own word waits, fourth byte held while slot busy (R8)
  assign elig = to_mem ? !(slot_busy && (slot_mine || last)) : full_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      word_q <= '0;
      cnt_q  <= '0;
      full_q <= 1'b0;
    end else if (load) begin
      word_q <= load_word;
      cnt_q  <= '0;
      full_q <= 1'b1;
    end else if (take) begin
      cnt_q <= cnt_q + lane_t'(1);
      if (to_mem)    word_q <= packed_word;
      else if (last) full_q <= 1'b0;
    end
  end

  a_r9_load_only_when_empty: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> !full_q);

  a_r8_owner_not_served: assert property (@(posedge clk) disable iff (!rst_n)
    (take && to_mem) |-> !slot_mine);
endmodule

// File: rtl/bp_word_slot.sv
module bp_word_slot
  import bytepack_pkg::*;
#(
  parameter int N = 2,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  word_t         push_word,
  input  logic [IW-1:0] push_ch,
  input  logic          wr_ready,
  output logic          wr_valid,
  output word_t         wr_data,
  output logic [IW-1:0] wr_chan
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_valid <= 1'b0;
      wr_data  <= '0;
      wr_chan  <= '0;
    end else if (push) begin
      wr_valid <= 1'b1;
      wr_data  <= push_word;
      wr_chan  <= push_ch;
    end else if (wr_valid && wr_ready) begin
      wr_valid <= 1'b0;
    end
  end

  a_r8_word_held: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_data) && $stable(wr_chan)));

  a_r8_push_into_free_slot: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> !wr_valid);
endmodule

// File: rtl/bp_fetch_ctrl.sv
module bp_fetch_ctrl #(
  parameter int N = 2,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  empty_vec,
  input  logic          rd_ready,
  output logic          rd_req,
  output logic [IW-1:0] rd_chan,
  output logic [N-1:0]  load_vec
);
  logic [IW-1:0] pick;

  always_comb begin
    pick = '0;
    for (int c = N - 1; c >= 0; c--)
      if (empty_vec[c]) pick = IW'(c);
  end

  always_comb begin
    load_vec = '0;
    if (rd_req && rd_ready) load_vec[rd_chan] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_req  <= 1'b0;
      rd_chan <= '0;
    end else if (rd_req) begin
      if (rd_ready) rd_req <= 1'b0;
    end else if (|empty_vec) begin
      rd_req  <= 1'b1;
      rd_chan <= pick;
    end
  end

  a_r9_fetch_held: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && !rd_ready) |=> (rd_req && $stable(rd_chan)));

  a_r9_fetch_target_empty: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |-> empty_vec[rd_chan]);
endmodule

// File: rtl/bytepack_dma.sv
module bytepack_dma
  import bytepack_pkg::*;
#(
  parameter int NUM_CH = 2,
  localparam int IW = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              big_endian,
  input  logic [NUM_CH-1:0] ch_to_mem,
  input  logic [NUM_CH-1:0] ch_req,
  output logic [NUM_CH-1:0] ch_ack_n,
  input  logic [7:0]        per_wdata_in,
  output logic [7:0]        per_rdata_out,
  output logic              wr_valid,
  input  logic              wr_ready,
  output logic [31:0]       wr_data,
  output logic [IW-1:0]     wr_chan,
  output logic              rd_req,
  input  logic              rd_ready,
  input  logic [31:0]       rd_data,
  output logic [IW-1:0]     rd_chan
);
  logic [NUM_CH-1:0] elig, cand, gnt, pack_done, empty_vec, load_vec;
  logic [IW-1:0]     gnt_idx;
  logic              gnt_any;
  byte_t             byte_vec   [NUM_CH];
  word_t             packed_vec [NUM_CH];
  word_t             push_word;

  assign cand     = ch_req & elig & {NUM_CH{rst_n}};
  assign ch_ack_n = ~gnt;

  bp_rr_arbiter #(.N(NUM_CH)) u_arb (
    .clk(clk), .rst_n(rst_n), .cand(cand),
    .gnt(gnt), .gnt_idx(gnt_idx), .any(gnt_any)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    bp_channel u_ch (
      .clk(clk), .rst_n(rst_n), .big(big_endian), .to_mem(ch_to_mem[c]),
      .take(gnt[c]), .byte_in(per_wdata_in),
      .load(load_vec[c]), .load_word(rd_data),
      .slot_busy(wr_valid), .slot_mine(wr_valid && (wr_chan == IW'(c))),
      .elig(elig[c]), .byte_out(byte_vec[c]), .pack_done(pack_done[c]),
      .packed_word(packed_vec[c]), .empty_rx(empty_vec[c])
    );
  end

  always_comb begin
    push_word = '0;
    for (int c = 0; c < NUM_CH; c++)
      if (pack_done[c]) push_word = packed_vec[c];
  end

  assign per_rdata_out = gnt_any ? byte_vec[gnt_idx] : '0;

  bp_word_slot #(.N(NUM_CH)) u_slot (
    .clk(clk), .rst_n(rst_n), .push(|pack_done), .push_word(push_word),
    .push_ch(gnt_idx), .wr_ready(wr_ready),
    .wr_valid(wr_valid), .wr_data(wr_data), .wr_chan(wr_chan)
  );

  bp_fetch_ctrl #(.N(NUM_CH)) u_fetch (
    .clk(clk), .rst_n(rst_n), .empty_vec(empty_vec), .rd_ready(rd_ready),
    .rd_req(rd_req), .rd_chan(rd_chan), .load_vec(load_vec)
  );

  a_r2_ack_only_on_request: assert property (@(posedge clk) disable iff (!rst_n)
    ((~ch_ack_n) & ~ch_req) == '0);

  a_r8_owner_stalled: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> ch_ack_n[wr_chan]);

  always_comb begin
    if (!rst_n) a_r1_no_ack_in_reset: assert (ch_ack_n == '1);
  end
endmodule

// File: tb/tb_bytepack_dma.sv
`timescale 1ns/1ps
module tb_bytepack_dma;
  localparam int N = 2;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          big_endian = 1'b0;
  logic [N-1:0]  ch_to_mem = '1;
  logic [N-1:0]  ch_req = '0;
  logic [N-1:0]  ch_ack_n;
  logic [7:0]    per_wdata_in = '0;
  logic [7:0]    per_rdata_out;
  logic          wr_valid;
  logic          wr_ready = 1'b0;
  logic [31:0]   wr_data;
  logic [0:0]    wr_chan;
  logic          rd_req;
  logic          rd_ready = 1'b0;
  logic [31:0]   rd_data = '0;
  logic [0:0]    rd_chan;

  always #2.5 clk = ~clk;

  bytepack_dma #(.NUM_CH(N)) dut (
    .clk(clk), .rst_n(rst_n), .big_endian(big_endian), .ch_to_mem(ch_to_mem),
    .ch_req(ch_req), .ch_ack_n(ch_ack_n), .per_wdata_in(per_wdata_in),
    .per_rdata_out(per_rdata_out), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_data(wr_data), .wr_chan(wr_chan), .rd_req(rd_req), .rd_ready(rd_ready),
    .rd_data(rd_data), .rd_chan(rd_chan)
  );

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 0;
  bit model_on = 0;

  // Reference state
  int          m_pos  [N];
  logic [31:0] m_word [N];
  bit          m_full [N];
  bit          s_v;
  logic [31:0] s_d;
  int          s_c;
  bit          f_v;
  int          f_c;
  int          last_served;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h at cycle %0d", req, what, act, exp, cycles);
    end
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  function automatic int lane_for(input int pos, input bit big);
    if (big) return 3 - pos;
    return pos;
  endfunction

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++;
      $display("FAIL watchdog expired actual=%0d expected=<150000", cycles);
      finish_up();
    end
  end

  // Reference model: compare, then advance to the state after the coming edge
  always @(negedge clk) begin
    if (model_on && rst_n) begin
      bit el [N];
      int g;
      int pick;
      logic [N-1:0] exp_ack;
      bit next_sv;
      g = -1;
      pick = -1;
      for (int c = 0; c < N; c++)
        el[c] = ch_to_mem[c] ? !(s_v && (s_c == c || m_pos[c] == 3)) : m_full[c];
      for (int k = 1; k <= N; k++) begin
        int idx;
        idx = (last_served + k) % N;
        if (g < 0 && ch_req[idx] && el[idx]) g = idx;
      end
      exp_ack = '1;
      if (g >= 0) exp_ack[g] = 1'b0;
      check(ch_ack_n == exp_ack, "R2/R6/R8", "ch_ack_n", 32'(ch_ack_n), 32'(exp_ack));
      if (g >= 0 && !ch_to_mem[g]) begin
        logic [7:0] eb;
        eb = m_word[g][8*lane_for(m_pos[g], big_endian) +: 8];
        check(per_rdata_out == eb, "R5/R7", "per_rdata_out", 32'(per_rdata_out), 32'(eb));
      end
      check(wr_valid == s_v, "R8", "wr_valid", 32'(wr_valid), 32'(s_v));
      if (s_v) begin
        check(wr_data == s_d, "R3/R4/R7", "wr_data", wr_data, s_d);
        check(int'(wr_chan) == s_c, "R10", "wr_chan", 32'(wr_chan), 32'(s_c));
      end
      check(rd_req == f_v, "R9", "rd_req", 32'(rd_req), 32'(f_v));
      if (f_v) check(int'(rd_chan) == f_c, "R9", "rd_chan", 32'(rd_chan), 32'(f_c));

      // fetch choice uses the state before this edge
      if (!f_v)
        for (int c = N - 1; c >= 0; c--)
          if (!ch_to_mem[c] && !m_full[c]) pick = c;

      next_sv = s_v && !wr_ready;
      if (g >= 0) begin
        last_served = g;
        if (ch_to_mem[g]) begin
          m_word[g][8*lane_for(m_pos[g], big_endian) +: 8] = per_wdata_in;
          if (m_pos[g] == 3) begin
            next_sv = 1;
            s_d = m_word[g];
            s_c = g;
            m_pos[g] = 0;
          end else m_pos[g]++;
        end else begin
          if (m_pos[g] == 3) begin
            m_full[g] = 0;
            m_pos[g] = 0;
          end else m_pos[g]++;
        end
      end
      s_v = next_sv;
      if (f_v) begin
        if (rd_ready) begin
          m_full[f_c] = 1;
          m_word[f_c] = rd_data;
          m_pos[f_c] = 0;
          f_v = 0;
        end
      end else if (pick >= 0) begin
        f_v = 1;
        f_c = pick;
      end
    end
  end

  task automatic do_reset(input bit big, input logic [N-1:0] dir);
    @(posedge clk); #1;
    model_on = 0;
    rst_n = 0;
    big_endian = big;
    ch_to_mem = dir;
    ch_req = '1;
    wr_ready = 0;
    rd_ready = 0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    check(ch_ack_n == '1, "R1", "ack in reset", 32'(ch_ack_n), 32'h3);
    check(wr_valid == 0, "R1", "wr_valid in reset", 32'(wr_valid), 0);
    check(rd_req == 0, "R1", "rd_req in reset", 32'(rd_req), 0);
    for (int c = 0; c < N; c++) begin
      m_pos[c] = 0; m_word[c] = '0; m_full[c] = 0;
    end
    s_v = 0; s_d = '0; s_c = 0; f_v = 0; f_c = 0; last_served = N - 1;
    @(posedge clk); #1;
    ch_req = '0;
    rst_n = 1;
    model_on = 1;
  endtask

  task automatic run_phase(input int n, input int req_pct, input int wr_pct, input int rd_pct);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1;
      for (int c = 0; c < N; c++) ch_req[c] = (($urandom % 100) < req_pct);
      per_wdata_in = 8'($urandom);
      wr_ready = (($urandom % 100) < wr_pct);
      rd_ready = (($urandom % 100) < rd_pct);
      rd_data = $urandom;
    end
  endtask

  // Four known bytes on channel 0, word then parked with wr_ready low
  task automatic directed_pack(input bit big);
    logic [7:0] bytes [4];
    logic [31:0] exp;
    bytes[0] = 8'h11; bytes[1] = 8'h22; bytes[2] = 8'h33; bytes[3] = 8'h44;
    exp = big ? 32'h11223344 : 32'h44332211;
    do_reset(big, 2'b11);
    for (int i = 0; i < 4; i++) begin
      @(posedge clk); #1;
      ch_req = 2'b01;
      per_wdata_in = bytes[i];
      wr_ready = 0;
    end
    for (int i = 0; i < 3; i++) begin
      @(posedge clk); #1;
      per_wdata_in = 8'hEE;
      @(negedge clk);
      check(ch_ack_n[0] == 1'b1, "R8", "owner ack while parked", 32'(ch_ack_n[0]), 1);
      if (big) check(wr_data == exp, "R4", "big-endian word", wr_data, exp);
      else     check(wr_data == exp, "R3", "little-endian word", wr_data, exp);
    end
    @(posedge clk); #1;
    ch_req = '0;
    wr_ready = 1;
    @(posedge clk); #1;
    wr_ready = 0;
  endtask

  initial begin
    directed_pack(1'b0);
    directed_pack(1'b1);
    do_reset(1'b0, 2'b11);
    run_phase(400, 80, 70, 50);
    do_reset(1'b1, 2'b11);
    run_phase(400, 90, 20, 50);
    do_reset(1'b0, 2'b00);
    run_phase(400, 80, 50, 40);
    do_reset(1'b1, 2'b10);
    run_phase(400, 85, 40, 30);
    do_reset(1'b0, 2'b01);
    run_phase(400, 100, 100, 100);
    @(posedge clk); #1;
    model_on = 0;
    repeat (2) @(posedge clk);
    finish_up();
  end
endmodule